// File: doc/BRIEF.md
# Bulk register packet assembler

This block sits on the manager side of a serial audio/control link and assembles one bulk register transfer per frame. It turns a request for one contiguous run of registers into a byte stream for the data port that inserts the packet into the frame payload. The request carries a target device number, the direction, a full 32-bit start address that uses no paging, a byte count and an active flag. In a write, the payload bytes arrive on a separate write-data port. They are passed through in order and are also folded into a data checksum.

Each packet is laid out as follows. Seven header content bytes come first, followed by a header CRC. After that come a slot that the peripheral fills with its header response, then the data slots and any zero padding. The packet closes with a data CRC slot and a footer slot that the peripheral fills with its footer response. Each byte carries a slot kind, start and end markers and a packet identifier, so the data port and software can track the stream. A request whose count exceeds the per-frame limit is refused with a one-cycle error pulse. An inactive request still produces a packet frame but moves no data.

Top module: `bra_pkt_asm`

## Requirements
- R1: Header bytes 0..6 are: byte 0 = {device[3:0], read bit, active bit, 2'b00}; bytes 1..4 = address, most significant byte first; byte 5 = 7'b0 followed by count bit 8; byte 6 = count[7:0]. All are tagged with kind 0 (header), and byte 0 alone has out_sop set.
- R2: Byte 7 (kind 1) is CRC-8 over header bytes 0..6, with polynomial 0x07, initial value 0xFF, most significant bit first.
- R3: Byte 8 (kind 2) is the header response slot and is driven as 0x00.
- R4: In a write, the payload bytes (kind 3) are emitted in arrival order. A write byte is consumed (wr_valid and wr_ready both high) only in the cycle in which it is emitted.
- R5: The data CRC slot (kind 5) uses the same CRC-8 over the payload bytes only. In a read it is 0x00 because the peripheral drives it.
- R6: The last byte of a packet is the footer slot (kind 6), value 0x00, with out_eop set. After it is taken, req_ready returns high.
- R7: Zero padding bytes (kind 4) follow the data, enough to bring data plus padding to a multiple of ALIGN (default 4). Padding is not included in the data CRC.
- R8: A request with count above MAX_BYTES (default 470) produces no packet and raises req_err for exactly one cycle after it is accepted. A count of exactly MAX_BYTES is accepted.
- R9: An inactive request emits a header with active bit 0 and count field 0, no data and no padding, a data CRC of 0xFF for a write, and the footer. It consumes no write bytes.
- R10: In a read, the data slots are 0x00 and no write byte is consumed.
- R11: out_pkt_id stays constant within a packet, starts at 0 after reset and increases by one after each emitted packet.
- R12: While out_valid is high and out_ready is low, the stream does not advance, and out_data, out_kind and out_sop hold their values.
- R13: After reset, req_ready is 1 and both out_valid and req_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_dev | input | 4 | Target device number |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 32 | Start register address |
| req_count | input | 9 | Payload byte count |
| req_active | input | 1 | Packet carries data |
| req_err | output | 1 | One-cycle pulse: request refused (count too large) |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Data port takes the byte |
| out_data | output | 8 | Stream byte |
| out_kind | output | 3 | Slot kind 0..6 (header, header CRC, header response, data, pad, data CRC, footer) |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| out_pkt_id | output | 4 | Packet identifier |

## Verification
In a write, a gap in the write-data supply and backpressure from the data port can occur in the same data cycle. The block must then neither consume the byte nor advance, and when either side resumes, the byte must come out once, in order, and be counted once in the data CRC. The bench drives out_ready and wr_valid from independent pseudo-random patterns, so both stall sources overlap often within the data phase. A scoreboard compares every emitted byte, kind, marker and identifier against a model of the packet, and a separate check confirms that stalled outputs hold.

// File: rtl/bra_pkg.sv
package bra_pkg;

    localparam int CNT_W     = 9;
    localparam int HDR_BYTES = 7;

    typedef enum logic [2:0] {
        K_HDR  = 3'd0,
        K_HCRC = 3'd1,
        K_HRSP = 3'd2,
        K_DATA = 3'd3,
        K_PAD  = 3'd4,
        K_DCRC = 3'd5,
        K_FRSP = 3'd6
    } slot_kind_t;

    typedef struct packed {
        logic [3:0]       dev;
        logic             rd;
        logic             act;
        logic [31:0]      addr;
        logic [CNT_W-1:0] cnt;
    } bra_req_t;

    // CRC-8, poly x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] d);
        logic [7:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [7:0] hdr_field(input bra_req_t r, input logic [2:0] idx);
        logic [15:0] cw;
        cw = 16'(r.cnt);
        case (idx)
            3'd0:    return {r.dev, r.rd, r.act, 2'b00};
            3'd1:    return r.addr[31:24];
            3'd2:    return r.addr[23:16];
            3'd3:    return r.addr[15:8];
            3'd4:    return r.addr[7:0];
            3'd5:    return cw[15:8];
            3'd6:    return cw[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bra_hdr_gen.sv
module bra_hdr_gen
    import bra_pkg::*;
(
    input  bra_req_t   req,
    input  logic [2:0] idx,
    output logic [7:0] byte_o,
    output logic [7:0] crc_o
);
    logic [7:0] acc;

    always_comb begin
        byte_o = hdr_field(req, idx);
        acc    = 8'hFF;
        for (int i = 0; i < HDR_BYTES; i++) begin
            acc = crc8_byte(acc, hdr_field(req, 3'(i)));
        end
        crc_o = acc;
    end
endmodule

// File: rtl/bra_crc_acc.sv
module bra_crc_acc
    import bra_pkg::*;
#(
    parameter logic [7:0] INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc_o
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc_o <= INIT;
        else if (en)      crc_o <= crc8_byte(crc_o, din);
    end
endmodule

// File: rtl/bra_seq.sv
module bra_seq
    import bra_pkg::*;
#(
    parameter int PAD_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] n_data,
    input  logic [PAD_W-1:0] n_pad,
    input  logic             adv,
    output slot_kind_t       kind,
    output logic [CNT_W-1:0] idx,
    output logic             busy
);
    slot_kind_t after_rsp, after_data;

    always_comb begin
        after_data = (n_pad != '0) ? K_PAD : K_DCRC;
        after_rsp  = (n_data != '0) ? K_DATA : after_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            kind <= K_HDR;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            kind <= K_HDR;
            idx  <= '0;
        end else if (busy && adv) begin
            case (kind)
                K_HDR: begin
                    if (idx == CNT_W'(HDR_BYTES - 1)) begin
                        kind <= K_HCRC;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                K_HCRC: kind <= K_HRSP;
                K_HRSP: begin
                    kind <= after_rsp;
                    idx  <= '0;
                end
                K_DATA: begin
                    if (idx == n_data - 1'b1) begin
                        kind <= after_data;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                K_PAD: begin
                    if (idx == CNT_W'(n_pad) - 1'b1) begin
                        kind <= K_DCRC;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                K_DCRC: kind <= K_FRSP;
                default: begin
                    busy <= 1'b0;
                    kind <= K_HDR;
                    idx  <= '0;
                end
            endcase
        end
    end

    // R1: the header index never passes the last content byte
    p_hdr_idx_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == K_HDR) |-> (idx < CNT_W'(HDR_BYTES)));

    // R7: the padding phase is entered only when padding is owed
    p_pad_owed_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == K_PAD) |-> (n_pad != '0));
endmodule

// File: rtl/bra_pkt_asm.sv
module bra_pkt_asm
    import bra_pkg::*;
#(
    parameter int MAX_BYTES = 470,
    parameter int ALIGN     = 4,
    parameter int PID_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_dev,
    input  logic             req_rd,
    input  logic [31:0]      req_addr,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_active,
    output logic             req_err,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic [2:0]       out_kind,
    output logic             out_sop,
    output logic             out_eop,
    output logic [PID_W-1:0] out_pkt_id
);
    localparam int PAD_W = $clog2(ALIGN + 1);

    bra_req_t         r_q;
    logic [PAD_W-1:0] n_pad;
    logic             accept, too_big, start, adv, busy;
    slot_kind_t       kind;
    logic [CNT_W-1:0] idx;
    logic [7:0]       hdr_byte, hdr_crc, dcrc;
    logic [PID_W-1:0] pid_q;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign too_big   = int'(req_count) > MAX_BYTES;
    assign start     = accept && !too_big;
    assign n_pad     = PAD_W'((ALIGN - (int'(r_q.cnt) % ALIGN)) % ALIGN);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            req_err <= 1'b0;
            pid_q   <= '0;
        end else begin
            req_err <= accept && too_big;
            if (start) begin
                r_q.dev  <= req_dev;
                r_q.rd   <= req_rd;
                r_q.act  <= req_active;
                r_q.addr <= req_addr;
                r_q.cnt  <= req_active ? req_count : '0;
            end
            if (adv && kind == K_FRSP) pid_q <= pid_q + 1'b1;
        end
    end

    bra_seq #(.PAD_W(PAD_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .n_data(r_q.cnt), .n_pad(n_pad),
        .adv(adv), .kind(kind), .idx(idx), .busy(busy)
    );

    bra_hdr_gen u_hdr (
        .req(r_q), .idx(idx[2:0]), .byte_o(hdr_byte), .crc_o(hdr_crc)
    );

    bra_crc_acc #(.INIT(8'hFF)) u_dcrc (
        .clk(clk), .rst(rst), .clear(start), .en(wr_valid && wr_ready),
        .din(wr_data), .crc_o(dcrc)
    );

    assign out_valid  = busy && !(kind == K_DATA && !r_q.rd && !wr_valid);
    assign adv        = out_valid && out_ready;
    assign wr_ready   = busy && kind == K_DATA && !r_q.rd && out_ready;
    assign out_kind   = kind;
    assign out_sop    = busy && kind == K_HDR && idx == '0;
    assign out_eop    = busy && kind == K_FRSP;
    assign out_pkt_id = pid_q;

    always_comb begin
        case (kind)
            K_HDR:   out_data = hdr_byte;
            K_HCRC:  out_data = hdr_crc;
            K_DATA:  out_data = r_q.rd ? 8'h00 : wr_data;
            K_DCRC:  out_data = r_q.rd ? 8'h00 : dcrc;
            default: out_data = 8'h00;
        endcase
    end

    // R8: a refused request leaves the block idle
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_ready);

    // R4: a write byte leaves only together with an accepted data slot
    p_wr_link_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |-> (out_valid && out_ready && out_kind == 3'(K_DATA)));

    // R10: reads never pull write bytes
    p_rd_nowr_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && r_q.rd) |-> !wr_ready);

    // R6: the footer ends the packet
    p_eop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eop) |=> req_ready);

    // R11: identifier fixed within a packet
    p_pid_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eop) |=> $stable(out_pkt_id));

    // R12: a stalled beat holds its slot
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_kind) && $stable(out_sop)));
endmodule

// File: tb/bra_pkt_asm_bench.sv
module bra_pkt_asm_bench;
    typedef struct packed {
        logic [7:0] d;
        logic [2:0] k;
        logic       sop;
        logic       eop;
        logic [3:0] pid;
    } beat_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_rd = 1'b0, req_active = 1'b0;
    logic [3:0] req_dev = '0;
    logic [31:0] req_addr = '0;
    logic [8:0] req_count = '0;
    logic req_ready, req_err, wr_ready, out_valid, out_sop, out_eop;
    logic wr_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] wr_data = '0, out_data;
    logic [2:0] out_kind;
    logic [3:0] out_pkt_id;

    int checks = 0, errors = 0, err_seen = 0;
    beat_t exp_q[$];
    logic [7:0] wq[$];
    logic [3:0] tb_pid = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic force_ready = 1'b0;

    always #10 clk = ~clk;

    bra_pkt_asm u_bra_pkt_asm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_rd(req_rd), .req_addr(req_addr),
        .req_count(req_count), .req_active(req_active), .req_err(req_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_kind(out_kind), .out_sop(out_sop), .out_eop(out_eop),
        .out_pkt_id(out_pkt_id)
    );

    function automatic logic [7:0] tb_crc(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4/R10";
            3'd4: return "R7";
            3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] k, input logic sop, input logic eop);
        beat_t b;
        b.d = d; b.k = k; b.sop = sop; b.eop = eop; b.pid = tb_pid;
        exp_q.push_back(b);
    endtask

    // driver: builds the expected packet, queues write bytes, offers the request
    task automatic send_req(input logic [3:0] dev, input logic rd, input logic [31:0] addr,
                            input int cnt, input logic act);
        logic [7:0] hb[7];
        logic [7:0] c;
        int n, npad;
        if (cnt <= 470) begin
            n = act ? cnt : 0;
            npad = (4 - (n % 4)) % 4;
            hb[0] = {dev, rd, act, 2'b00};
            hb[1] = addr[31:24]; hb[2] = addr[23:16]; hb[3] = addr[15:8]; hb[4] = addr[7:0];
            hb[5] = {7'b0, 9'(n) >> 8}; hb[6] = 8'(n);
            c = 8'hFF;
            for (int i = 0; i < 7; i++) begin
                push(hb[i], 3'd0, i == 0, 1'b0);
                c = tb_crc(c, hb[i]);
            end
            push(c, 3'd1, 1'b0, 1'b0);
            push(8'h00, 3'd2, 1'b0, 1'b0);
            c = 8'hFF;
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                d = addr[7:0] ^ 8'(i * 37 + 5);
                if (rd) push(8'h00, 3'd3, 1'b0, 1'b0);
                else begin
                    push(d, 3'd3, 1'b0, 1'b0);
                    wq.push_back(d);
                    c = tb_crc(c, d);
                end
            end
            for (int i = 0; i < npad; i++) push(8'h00, 3'd4, 1'b0, 1'b0);
            push(rd ? 8'h00 : c, 3'd5, 1'b0, 1'b0);
            push(8'h00, 3'd6, 1'b0, 1'b1);
            tb_pid++;
        end
        @(posedge clk); #1;
        req_dev = dev; req_rd = rd; req_addr = addr; req_count = 9'(cnt);
        req_active = act; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // output-ready pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = force_ready | lfsr[0] | lfsr[3];
        end
    end

    // write-data feeder with gaps
    initial begin
        forever begin
            bit take;
            @(negedge clk);
            take = wr_valid && wr_ready;
            @(posedge clk); #1;
            if (take && wq.size() > 0) void'(wq.pop_front());
            wr_valid = (wq.size() > 0) && (lfsr[5] | lfsr[7]);
            wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
        end
    end

    // monitor / scoreboard
    initial begin
        bit stalled = 0;
        logic [7:0] s_d;
        logic [2:0] s_k;
        logic s_sop;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (req_err) err_seen++;
                if (stalled && out_valid)
                    check(out_data == s_d && out_kind == s_k && out_sop == s_sop,
                          "R12 hold", {out_sop, out_kind, out_data}, {s_sop, s_k, s_d});
                stalled = out_valid && !out_ready;
                s_d = out_data; s_k = out_kind; s_sop = out_sop;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 extra beat", {out_kind, out_data}, 0);
                    end else begin
                        beat_t e;
                        e = exp_q.pop_front();
                        check(out_data == e.d && out_kind == e.k, tag_of(e.k),
                              {out_kind, out_data}, {e.k, e.d});
                        check(out_sop == e.sop && out_eop == e.eop && out_pkt_id == e.pid,
                              "R11 markers/id", {out_sop, out_eop, out_pkt_id},
                              {e.sop, e.eop, e.pid});
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R13 req_ready", req_ready, 1);
        check(out_valid == 1'b0, "R13 out_valid", out_valid, 0);
        check(req_err == 1'b0, "R13 req_err", req_err, 0);
        @(posedge clk); #1;
        rst = 1'b0;

        send_req(4'h5, 1'b0, 32'h1234_5678, 5, 1'b1);      // pad 3
        send_req(4'hA, 1'b0, 32'hDEAD_0001, 8, 1'b1);      // no pad
        wait_idle();

        wq.push_back(8'hA5);                               // sentinel for R9/R10
        send_req(4'h3, 1'b1, 32'h0000_4000, 6, 1'b1);      // read
        send_req(4'h7, 1'b0, 32'h0BAD_F00D, 10, 1'b0);     // inactive write
        wait_idle();
        send_req(4'h2, 1'b0, 32'h0000_0100, 471, 1'b1);    // over limit
        @(negedge clk);
        check(req_err == 1'b1, "R8 err pulse", req_err, 1);
        check(out_valid == 1'b0, "R8 no packet", out_valid, 0);
        @(negedge clk);
        check(req_err == 1'b0, "R8 single cycle", req_err, 0);
        check(wq.size() == 1, "R9 R10 sentinel untouched", wq.size(), 1);
        void'(wq.pop_front());
        repeat (3) @(posedge clk);

        send_req(4'h1, 1'b0, 32'h8000_0000, 0, 1'b1);      // empty active write
        send_req(4'hF, 1'b1, 32'hFFFF_FFF0, 3, 1'b1);
        send_req(4'h9, 1'b0, 32'h0001_0002, 470, 1'b1);    // boundary R8
        for (int i = 0; i < 6; i++)
            send_req(4'(i), 1'(i % 2), 32'h100 * i + 7, i * 3 + 1, 1'b1);
        wait_idle();
        force_ready = 1'b1;
        send_req(4'h4, 1'b0, 32'h5555_AAAA, 13, 1'b1);
        wait_idle();

        check(err_seen == 1, "R8 error count", err_seen, 1);
        check(exp_q.size() == 0, "R6 all beats out", exp_q.size(), 0);
        check(wq.size() == 0, "R4 all write bytes used", wq.size(), 0);
        check(req_ready == 1'b1, "R6 idle at end", req_ready, 1);
        finish_run();
    end
endmodule